// File: doc/BRIEF.md
# Interval Timer Latch and Read-Back Unit

This block holds the snapshot and byte-read logic of a three-channel interval timer. The host writes control bytes to one address and reads counter bytes from three data addresses. A control byte can freeze a counter's running 16-bit value, its 8-bit status, or both. Later byte reads from that counter's address return the frozen values, one byte per read, until they have been consumed. While nothing is frozen, reads return the running count directly.

The counting core is not part of this block. Each channel provides its live count, its live status byte and a 2-bit byte-access mode as inputs. Two command forms can freeze values. The single-counter snapshot form names one counter and freezes only its count. The multi-counter form selects counters with a bit mask and takes separate active-low requests for count and status. A frozen value is never replaced before it has been fully read. Each channel tracks its own state, so the host may access the other counters between the two byte reads of a frozen count.

Top module: `pit_latch_readback`

## Requirements
- R1: `addr_i` values 0, 1 and 2 are the data addresses of counters 0, 1 and 2, and value 3 is the control address. A read from address 3 returns 0x00.
- R2: A control byte with bits[5:4]=00 and bits[7:6]≠11 freezes the count of the counter numbered by bits[7:6]. The frozen value is the live count in the cycle of the write.
- R3: While a counter's frozen count has not been fully read, a further snapshot request for that counter is ignored. The reads still return the first frozen value.
- R4: A control byte with bits[7:6]=11 is a multi-counter command. Bits 1, 2 and 3 select counters 0, 1 and 2. Bit 5=0 requests a count freeze and bit 4=0 requests a status freeze. Counters that are not selected are unaffected.
- R5: When both status and count are frozen, the first read returns the status byte. The following reads return the count bytes, low byte first.
- R6: A frozen status that has not been read is not replaced by a later status request. A single read releases it.
- R7: `mode_i` holds 2 bits per counter: 01 selects low byte only, 10 high byte only, and 11 or 00 two-byte access (low byte, then high byte). A frozen count is released after one read in the single-byte modes and after two reads in two-byte mode.
- R8: Reads of other counters and control writes addressed to other counters that fall between the two byte reads of a frozen count do not disturb it.
- R9: With nothing frozen, reads return the live count bytes. They follow the mode and the counter's own low/high toggle.
- R10: A mode-setting control byte (bits[7:6]≠11, bits[5:4]≠00) discards any frozen count or status of the named counter and resets its byte toggle to low.
- R11: A multi-counter command that requests both freezes for a counter whose count is already frozen freezes only the status. The reads then return the new status, followed by the original count.
- R12: After reset nothing is frozen and every byte toggle points at the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe, consumes the byte shown on rdata_o |
| addr_i | input | 2 | Host address: 0..2 counter data, 3 control |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Byte for the current address, valid while rd_i is high |
| live_count_i | input | 48 | Live 16-bit counts, counter n at bits [16n+15:16n] |
| live_status_i | input | 24 | Live status bytes, counter n at bits [8n+7:8n] |
| mode_i | input | 6 | Byte-access mode per counter, counter n at bits [2n+1:2n] |

## Verification
A single multi-counter command can carry a status freeze and a count freeze for the same counter in the same cycle, and either can collide with an earlier freeze that is still pending. The bench provokes this in two ways. First it freezes a count with the single-counter form, then moves the live count and status, then issues the combined command. It then judges the read sequence: the fresh status byte must come first, followed by the old count. The bench also repeats status-only and count-only requests on pending values and checks that the first snapshot survives.

// File: rtl/pit_lr_pkg.sv
package pit_lr_pkg;
  typedef enum logic [1:0] {
    AM_TWO_ALT = 2'b00,
    AM_LOW     = 2'b01,
    AM_HIGH    = 2'b10,
    AM_TWO     = 2'b11
  } acc_mode_e;

  localparam int unsigned CNT_W = 16;
  localparam int unsigned STS_W = 8;
  localparam logic [1:0]  CTRL_ADDR = 2'd3;
endpackage

// File: rtl/pit_lr_dec.sv
module pit_lr_dec #(
  parameter int unsigned NCH = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [1:0]     addr_i,
  input  logic [7:0]     wdata_i,
  output logic [NCH-1:0] lat_cnt_o,
  output logic [NCH-1:0] lat_sts_o,
  output logic [NCH-1:0] clr_o
);
  import pit_lr_pkg::*;

  logic ctl_wr, multi, single_snap;

  always_comb begin
    ctl_wr      = wr_i && (addr_i == CTRL_ADDR);
    multi       = ctl_wr && (wdata_i[7:6] == 2'b11);
    single_snap = ctl_wr && !multi && (wdata_i[5:4] == 2'b00);
    for (int i = 0; i < NCH; i++) begin
      lat_cnt_o[i] = (multi && wdata_i[i+1] && !wdata_i[5]) ||
                     (single_snap && (wdata_i[7:6] == 2'(i)));
      lat_sts_o[i] = multi && wdata_i[i+1] && !wdata_i[4];
      clr_o[i]     = ctl_wr && !multi && !single_snap && (wdata_i[7:6] == 2'(i));
    end
  end

  p_clr_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));
  p_clr_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_o) |-> !(|lat_cnt_o) && !(|lat_sts_o));
endmodule

// File: rtl/pit_lr_chan.sv
module pit_lr_chan
  import pit_lr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] live_cnt_i,
  input  logic [STS_W-1:0] live_sts_i,
  input  logic [1:0]       mode_i,
  input  logic             rd_i,
  input  logic             lat_cnt_i,
  input  logic             lat_sts_i,
  input  logic             clr_i,
  output logic [7:0]       rd_byte_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [STS_W-1:0] sts_q, sts_n;
  logic             cnt_pend_q, cnt_pend_n;
  logic             sts_pend_q, sts_pend_n;
  logic             hi_q, hi_n;
  logic [CNT_W-1:0] src;
  logic             two_byte;

  always_comb begin
    two_byte = (mode_i == AM_TWO) || (mode_i == AM_TWO_ALT);
    src      = cnt_pend_q ? cnt_q : live_cnt_i;
    if (sts_pend_q)                rd_byte_o = sts_q;
    else if (mode_i == AM_LOW)     rd_byte_o = src[7:0];
    else if (mode_i == AM_HIGH)    rd_byte_o = src[15:8];
    else                           rd_byte_o = hi_q ? src[15:8] : src[7:0];
  end

  always_comb begin
    cnt_n      = cnt_q;
    sts_n      = sts_q;
    cnt_pend_n = cnt_pend_q;
    sts_pend_n = sts_pend_q;
    hi_n       = hi_q;
    if (rd_i) begin
      if (sts_pend_q) sts_pend_n = 1'b0;
      else begin
        if (two_byte) hi_n = ~hi_q;
        if (cnt_pend_q && (!two_byte || hi_q)) cnt_pend_n = 1'b0;
      end
    end
    if (clr_i) begin
      cnt_pend_n = 1'b0;
      sts_pend_n = 1'b0;
      hi_n       = 1'b0;
    end else begin
      // first snapshot wins until consumed
      if (lat_cnt_i && !cnt_pend_q) begin
        cnt_pend_n = 1'b1;
        cnt_n      = live_cnt_i;
      end
      if (lat_sts_i && !sts_pend_q) begin
        sts_pend_n = 1'b1;
        sts_n      = live_sts_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      sts_q      <= '0;
      cnt_pend_q <= 1'b0;
      sts_pend_q <= 1'b0;
      hi_q       <= 1'b0;
    end else begin
      cnt_q      <= cnt_n;
      sts_q      <= sts_n;
      cnt_pend_q <= cnt_pend_n;
      sts_pend_q <= sts_pend_n;
      hi_q       <= hi_n;
    end
  end

  p_cnt_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnt_pend_q) |-> cnt_q == $past(live_cnt_i));
  p_cnt_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_pend_q && $past(cnt_pend_q)) |-> $stable(cnt_q));
  p_sts_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_pend_q) |-> sts_q == $past(live_sts_i));
  p_sts_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_pend_q && $past(sts_pend_q)) |-> $stable(sts_q));
  p_sts_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sts_pend_q && !clr_i && !lat_cnt_i) |=> !sts_pend_q && $stable(cnt_pend_q));
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !cnt_pend_q && !sts_pend_q && !hi_q);
endmodule

// File: rtl/pit_latch_readback.sv
module pit_latch_readback
  import pit_lr_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [1:0]         addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  logic [NCH*16-1:0]  live_count_i,
  input  logic [NCH*8-1:0]   live_status_i,
  input  logic [NCH*2-1:0]   mode_i
);
  logic [NCH-1:0] lat_cnt, lat_sts, clr, rd_sel;
  logic [7:0]     ch_byte [NCH];

  pit_lr_dec #(.NCH(NCH)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .lat_cnt_o (lat_cnt),
    .lat_sts_o (lat_sts),
    .clr_o     (clr)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign rd_sel[g] = rd_i && (addr_i == 2'(g));
    pit_lr_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .live_cnt_i (live_count_i[g*16 +: 16]),
      .live_sts_i (live_status_i[g*8 +: 8]),
      .mode_i     (mode_i[g*2 +: 2]),
      .rd_i       (rd_sel[g]),
      .lat_cnt_i  (lat_cnt[g]),
      .lat_sts_i  (lat_sts[g]),
      .clr_i      (clr[g]),
      .rd_byte_o  (ch_byte[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++)
      if (addr_i == 2'(i)) rdata_o = ch_byte[i];
  end

  p_ctl_read_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == CTRL_ADDR) |-> rdata_o == 8'h00);
  p_rd_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_sel));
endmodule

// File: tb/pit_latch_readback_tb.sv
module pit_latch_readback_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [15:0] lv [3];
  logic [7:0]  ls [3];
  logic [1:0]  md [3];
  logic [47:0] lv_bus;
  logic [23:0] ls_bus;
  logic [5:0]  md_bus;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  assign lv_bus = {lv[2], lv[1], lv[0]};
  assign ls_bus = {ls[2], ls[1], ls[0]};
  assign md_bus = {md[2], md[1], md[0]};

  pit_latch_readback u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .live_count_i(lv_bus),
    .live_status_i(ls_bus), .mode_i(md_bus)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] b);
    @(negedge clk);
    addr = 2'd3; wdata = b; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_byte(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = 2'(a); rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic [7:0] mode_word(input int c);
    return 8'(c << 6) | 8'h30;
  endfunction

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [15:0] a_v, b_v;
    for (int c = 0; c < 3; c++) begin
      lv[c] = 16'h0; ls[c] = 8'h0; md[c] = 2'b11;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 / R1 / R9
    rd_byte(3, d); chk("R1 control read", d, 8'h00);
    lv[0] = 16'h1234;
    rd_byte(0, d); chk("R12 toggle low after reset", d, 8'h34);
    rd_byte(0, d); chk("R9 live high", d, 8'h12);

    // R2 R3 R7 R8 R9 sweep over counters and byte modes
    for (int c = 0; c < 3; c++) begin
      for (int m = 1; m < 4; m++) begin
        int o;
        o = (c + 1) % 3;
        md[c] = 2'(m);
        wr_ctl(mode_word(c));
        a_v = 16'hA000 + 16'(c * 16'h0100) + 16'(m * 16'h0011);
        b_v = ~a_v;
        lv[c] = a_v;
        wr_ctl(8'(c << 6));
        lv[c] = b_v;
        wr_ctl(8'(c << 6));            // R3 ignored
        if (m == 3) begin
          rd_byte(c, d); chk("R2 frozen low", d, a_v[7:0]);
          rd_byte(o, d);               // R8 interleave
          wr_ctl(8'(o << 6));
          rd_byte(c, d); chk("R8 frozen high after interleave", d, a_v[15:8]);
          rd_byte(c, d); chk("R9 live low after release", d, b_v[7:0]);
        end else begin
          rd_byte(c, d);
          chk("R7 single-byte frozen", d, (m == 1) ? a_v[7:0] : a_v[15:8]);
          rd_byte(c, d);
          chk("R7 released after one read", d, (m == 1) ? b_v[7:0] : b_v[15:8]);
        end
      end
    end
    for (int c = 0; c < 3; c++) begin
      md[c] = 2'b11;
      wr_ctl(mode_word(c));
    end

    // R4 R5 multi-counter both, counters 0 and 2
    for (int c = 0; c < 3; c++) begin
      lv[c] = 16'h5A00 + 16'(c * 16'h0111);
      ls[c] = 8'h80 | 8'(c);
    end
    wr_ctl(8'hCA);
    for (int c = 0; c < 3; c++) begin
      lv[c] = 16'h0F0F; ls[c] = 8'h55;
    end
    rd_byte(0, d); chk("R5 status first c0", d, 8'h80);
    rd_byte(0, d); chk("R5 count low c0", d, 8'h00);
    rd_byte(0, d); chk("R5 count high c0", d, 8'h5A);
    rd_byte(1, d); chk("R4 unselected live", d, 8'h0F);
    rd_byte(1, d);
    rd_byte(2, d); chk("R4 status c2", d, 8'h82);
    rd_byte(2, d); chk("R4 count low c2", d, 8'h22);
    rd_byte(2, d); chk("R4 count high c2", d, 8'h5C);

    // R6 status-only repeat
    ls[0] = 8'h11; lv[0] = 16'hBEEF;
    wr_ctl(8'hE2);
    ls[0] = 8'h22;
    wr_ctl(8'hE2);
    rd_byte(0, d); chk("R6 first status kept", d, 8'h11);
    rd_byte(0, d); chk("R6 released, live low", d, 8'hEF);
    rd_byte(0, d);
    wr_ctl(8'hD2);                     // count only
    lv[0] = 16'h0000;
    rd_byte(0, d); chk("R4 count-only low", d, 8'hEF);
    rd_byte(0, d); chk("R4 count-only high", d, 8'hBE);

    // R11 combined request while count pending
    lv[1] = 16'hC3A5;
    wr_ctl(8'h40);
    lv[1] = 16'h7777; ls[1] = 8'h3C;
    wr_ctl(8'hC4);
    rd_byte(1, d); chk("R11 new status", d, 8'h3C);
    rd_byte(1, d); chk("R11 old count low", d, 8'hA5);
    rd_byte(1, d); chk("R11 old count high", d, 8'hC3);

    // R10 mode word discards snapshot
    lv[2] = 16'h1357;
    wr_ctl(8'h80);
    rd_byte(2, d);
    lv[2] = 16'h9BDF;
    wr_ctl(mode_word(2));
    rd_byte(2, d); chk("R10 cleared, live low", d, 8'hDF);
    rd_byte(2, d); chk("R10 live high", d, 8'h9B);

    // R7 mode 00 as two-byte
    md[0] = 2'b00;
    wr_ctl(mode_word(0));
    lv[0] = 16'h4C2D;
    wr_ctl(8'h00);
    lv[0] = 16'h0000;
    rd_byte(0, d); chk("R7 mode00 low", d, 8'h2D);
    rd_byte(0, d); chk("R7 mode00 high", d, 8'h4C);
    rd_byte(0, d); chk("R7 mode00 released", d, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule